// File: doc/BRIEF.md
# MSI-X Capability and Vector Table

This block holds the message-signalled interrupt capability structure of a PCI function together with the vector table behind it. Software reads and writes the capability header through a configuration access port. Software reads and writes the vector table through a separate 32-bit memory-mapped port. Each vector owns a message address, a message data word and a mask flag.

Device logic raises interrupts on per-vector request lines. Every request is first latched as a pending bit. A pending vector becomes a message write when three conditions hold: the capability is enabled, the function-wide mask is clear, and the vector itself is unmasked. Message writes leave on a valid/ready output. If several vectors are eligible at once, the lowest index goes first.

The number of vectors, the table and pending-array locators (offset plus BAR indicator) and the next-capability pointer are parameters. Decoding the BAR and presenting the pending array to software are left to the surrounding logic.

Top module: `msix_vec_table`

## Requirements
- R1: Out of reset, the header dword at offset 0 reads {control[15:0], next pointer[7:0], 8'h11}. In the control word, bits 10:0 hold the vector count minus one, bit 14 is the function mask and bit 15 is the enable. Both of those bits read 0 after reset.
- R2: Only a configuration write with size 2 at offset 2 changes the header. Such a write copies bit 15 of the write data (enable) and bit 14 (function mask) and nothing else. Writes of any other size or offset leave the header unchanged.
- R3: The dwords at offsets 4 and 8 read as the table locator and the pending-array locator. In each, the BAR indicator sits in bits 2:0 and the 8-byte-aligned offset in bits 31:3. The dword at offset 12 reads 0.
- R4: The table holds 16 bytes per vector at byte address 16*index. Address low is at +0, address high at +4, message data at +8 and vector control at +12. Each word written there reads back unchanged, except the vector control word.
- R5: After reset every vector's address and data words read 0 and its vector control reads 1 (masked).
- R6: A table access whose size is not 4, or whose address bits 1:0 are not 0, changes nothing. A read of that kind returns 0.
- R7: A table access whose vector index is at or beyond the vector count changes nothing. A read of that kind returns 0.
- R8: Reading vector control returns only the stored mask in bit 0. A write to vector control that flips the stored mask raises mask_changed for exactly the one cycle after the write edge. A write that does not flip the mask leaves mask_changed low.
- R9: A request on an eligible vector produces a message whose address is {address high, address low} and whose data is the vector's data word. msg_valid rises on the second clock edge after the request is sampled.
- R10: A request on a vector that is not eligible stays pending, and no message is sent while the vector remains blocked. Once the vector becomes eligible, the pending request is sent exactly once.
- R11: When several vectors are pending and eligible, they are sent one message at a time, lowest index first.
- R12: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 4 | Byte offset within the capability |
| cfg_size | input | 3 | Access size in bytes (1, 2 or 4) |
| cfg_wdata | input | 32 | Write data, a 16-bit value in bits 15:0 |
| cfg_rdata | output | 32 | Aligned dword selected by cfg_addr[3:2] |
| tbl_valid | input | 1 | Table access strobe |
| tbl_write | input | 1 | 1 = write, 0 = read |
| tbl_addr | input | TBL_AW | Byte address within the table window |
| tbl_size | input | 3 | Access size in bytes |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data, combinational |
| mask_changed | output | 1 | One-cycle pulse after a mask flip |
| irq_req | input | NUM_VEC | Per-vector interrupt requests |
| msg_valid | output | 1 | Message write available |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The checks assume the following about the inputs:
- Every access carries a size of 1, 2 or 4.
- Configuration and table strobes last a single clock per access.
- msg_ready may be asserted at any time.

The bench drives every access at the falling edge and lowers the strobe one cycle later. Table writes go to random vector/field pairs, checked against a shadow model. Irregular sizes, misaligned addresses and out-of-range indexes are aimed deliberately. msg_ready stays low for stretches so that the hold rule is actually tested.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam logic [7:0] CAP_ID = 8'h11;

  // a table access is legal only as an aligned dword
  function automatic logic dword_access_ok(input logic [1:0] lo, input logic [2:0] size);
    return (size == 3'd4) && (lo == 2'b00);
  endfunction

  // offset register: 8-byte aligned offset above a 3-bit BAR indicator
  function automatic logic [31:0] locator_word(input logic [31:0] ofs, input logic [2:0] bir);
    return {ofs[31:3], bir};
  endfunction

  // first header dword
  function automatic logic [31:0] header_word(input logic en, input logic fm,
                                             input logic [10:0] size_m1, input logic [7:0] nxt);
    return {en, fm, 3'b000, size_m1, nxt, CAP_ID};
  endfunction
endpackage

// File: rtl/msix_cap_hdr.sv
module msix_cap_hdr #(
  parameter int          NUM_VEC  = 8,
  parameter logic [7:0]  NEXT_PTR = 8'h00,
  parameter logic [31:0] TBL_OFS  = 32'h0000_2000,
  parameter logic [2:0]  TBL_BIR  = 3'd2,
  parameter logic [31:0] PBA_OFS  = 32'h0000_3000,
  parameter logic [2:0]  PBA_BIR  = 3'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic        cfg_write,
  input  logic [3:0]  cfg_addr,
  input  logic [2:0]  cfg_size,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        hdr_en,
  output logic        hdr_fm
);
  localparam logic [10:0] SIZE_M1 = 11'(NUM_VEC - 1);

  logic ctrl_wr;
  assign ctrl_wr = cfg_valid && cfg_write && (cfg_size == 3'd2) && (cfg_addr == 4'd2);

  wire unused_wbits = ^{cfg_wdata[31:16], cfg_wdata[13:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_en <= 1'b0;
      hdr_fm <= 1'b0;
    end else if (ctrl_wr) begin
      hdr_en <= cfg_wdata[15];
      hdr_fm <= cfg_wdata[14];
    end
  end

  always_comb begin
    unique case (cfg_addr[3:2])
      2'd0:    cfg_rdata = msix_pkg::header_word(hdr_en, hdr_fm, SIZE_M1, NEXT_PTR);
      2'd1:    cfg_rdata = msix_pkg::locator_word(TBL_OFS, TBL_BIR);
      2'd2:    cfg_rdata = msix_pkg::locator_word(PBA_OFS, PBA_BIR);
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msix_vec_store.sv
module msix_vec_store #(
  parameter int NUM_VEC = 8,
  parameter int TBL_AW  = 8,
  localparam int VIW    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int IDXW   = TBL_AW - 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [TBL_AW-1:0]  acc_addr,
  input  logic [2:0]         acc_size,
  input  logic [31:0]        acc_wdata,
  output logic [31:0]        acc_rdata,
  output logic               mask_flip,
  output logic [NUM_VEC-1:0] mask_vec,
  input  logic [VIW-1:0]     sel_idx,
  output logic [63:0]        sel_addr,
  output logic [31:0]        sel_data
);
  logic [31:0] lo_q  [NUM_VEC];
  logic [31:0] hi_q  [NUM_VEC];
  logic [31:0] dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] msk_q;

  logic [IDXW-1:0] ent;
  logic [VIW-1:0]  vi;
  logic [1:0]      fld;
  logic            hit;

  assign ent = acc_addr[TBL_AW-1:4];
  assign vi  = ent[VIW-1:0];
  assign fld = acc_addr[3:2];
  assign hit = acc_valid && msix_pkg::dword_access_ok(acc_addr[1:0], acc_size)
               && (int'(ent) < NUM_VEC);

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    logic wr_here;
    assign wr_here = hit && acc_write && (int'(vi) == g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[g]  <= '0;
        hi_q[g]  <= '0;
        dat_q[g] <= '0;
        msk_q[g] <= 1'b1;
      end else if (wr_here) begin
        unique case (fld)
          2'd0: lo_q[g]  <= acc_wdata;
          2'd1: hi_q[g]  <= acc_wdata;
          2'd2: dat_q[g] <= acc_wdata;
          default: msk_q[g] <= acc_wdata[0];
        endcase
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (hit && !acc_write) begin
      unique case (fld)
        2'd0: acc_rdata = lo_q[vi];
        2'd1: acc_rdata = hi_q[vi];
        2'd2: acc_rdata = dat_q[vi];
        default: acc_rdata = {31'd0, msk_q[vi]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_flip <= 1'b0;
    else        mask_flip <= hit && acc_write && (fld == 2'd3) && (acc_wdata[0] != msk_q[vi]);
  end

  assign mask_vec = msk_q;
  assign sel_addr = {hi_q[sel_idx], lo_q[sel_idx]};
  assign sel_data = dat_q[sel_idx];
endmodule

// File: rtl/msix_dispatch.sv
module msix_dispatch #(
  parameter int NUM_VEC = 8,
  localparam int VIW    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic [NUM_VEC-1:0] mask_vec,
  input  logic               fn_on,
  input  logic [63:0]        sel_addr,
  input  logic [31:0]        sel_data,
  output logic [VIW-1:0]     sel_idx,
  output logic [NUM_VEC-1:0] grant,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  function automatic logic [VIW-1:0] lowest_set(input logic [NUM_VEC-1:0] v);
    lowest_set = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) if (v[i]) lowest_set = VIW'(i);
  endfunction

  logic [NUM_VEC-1:0] pend_q, eligible;
  logic slot_free, load_go;

  assign eligible  = pend_q & ~mask_vec & {NUM_VEC{fn_on}};
  assign slot_free = !msg_valid || msg_ready;
  assign load_go   = (|eligible) && slot_free;
  assign sel_idx   = lowest_set(eligible);
  assign grant     = load_go ? (NUM_VEC'(1) << sel_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~grant) | irq_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load_go) begin
      msg_valid <= 1'b1;
      msg_addr  <= sel_addr;
      msg_data  <= sel_data;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/msix_vec_table.sv
module msix_vec_table #(
  parameter int          NUM_VEC  = 8,
  parameter int          TBL_AW   = 8,
  parameter logic [7:0]  NEXT_PTR = 8'h00,
  parameter logic [31:0] TBL_OFS  = 32'h0000_2000,
  parameter logic [2:0]  TBL_BIR  = 3'd2,
  parameter logic [31:0] PBA_OFS  = 32'h0000_3000,
  parameter logic [2:0]  PBA_BIR  = 3'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic               cfg_write,
  input  logic [3:0]         cfg_addr,
  input  logic [2:0]         cfg_size,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               tbl_valid,
  input  logic               tbl_write,
  input  logic [TBL_AW-1:0]  tbl_addr,
  input  logic [2:0]         tbl_size,
  input  logic [31:0]        tbl_wdata,
  output logic [31:0]        tbl_rdata,
  output logic               mask_changed,
  input  logic [NUM_VEC-1:0] irq_req,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int VIW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic               hdr_en, hdr_fm;
  logic [NUM_VEC-1:0] mask_vec, grant;
  logic [VIW-1:0]     sel_idx;
  logic [63:0]        sel_addr;
  logic [31:0]        sel_data;

  msix_cap_hdr #(
    .NUM_VEC(NUM_VEC), .NEXT_PTR(NEXT_PTR), .TBL_OFS(TBL_OFS),
    .TBL_BIR(TBL_BIR), .PBA_OFS(PBA_OFS), .PBA_BIR(PBA_BIR)
  ) u_hdr (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .hdr_en(hdr_en), .hdr_fm(hdr_fm)
  );

  msix_vec_store #(.NUM_VEC(NUM_VEC), .TBL_AW(TBL_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .acc_valid(tbl_valid), .acc_write(tbl_write),
    .acc_addr(tbl_addr), .acc_size(tbl_size), .acc_wdata(tbl_wdata),
    .acc_rdata(tbl_rdata), .mask_flip(mask_changed), .mask_vec(mask_vec),
    .sel_idx(sel_idx), .sel_addr(sel_addr), .sel_data(sel_data)
  );

  msix_dispatch #(.NUM_VEC(NUM_VEC)) u_disp (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_vec(mask_vec),
    .fn_on(hdr_en && !hdr_fm), .sel_addr(sel_addr), .sel_data(sel_data),
    .sel_idx(sel_idx), .grant(grant), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/msix_vec_table_chk.sv
module msix_vec_table_chk #(
  parameter int NUM_VEC = 8,
  parameter int TBL_AW  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_valid,
  input logic               cfg_write,
  input logic [3:0]         cfg_addr,
  input logic [2:0]         cfg_size,
  input logic               hdr_en,
  input logic               hdr_fm,
  input logic               tbl_valid,
  input logic               tbl_write,
  input logic [TBL_AW-1:0]  tbl_addr,
  input logic [2:0]         tbl_size,
  input logic [31:0]        tbl_rdata,
  input logic               mask_changed,
  input logic [NUM_VEC-1:0] grant,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data
);
  // R12
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R9
  send_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(hdr_en && !hdr_fm));

  // R2
  header_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_write && cfg_size == 3'd2 && cfg_addr == 4'd2)
      |=> $stable(hdr_en) && $stable(hdr_fm));

  // R8
  mask_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_changed |-> $past(tbl_valid && tbl_write && tbl_addr[3:2] == 2'd3));

  // R6
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_valid && !tbl_write && (tbl_size != 3'd4 || tbl_addr[1:0] != 2'b00) |-> tbl_rdata == 32'd0);

  // R11
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind msix_vec_table msix_vec_table_chk #(.NUM_VEC(NUM_VEC), .TBL_AW(TBL_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
  .cfg_addr(cfg_addr), .cfg_size(cfg_size), .hdr_en(hdr_en), .hdr_fm(hdr_fm),
  .tbl_valid(tbl_valid), .tbl_write(tbl_write), .tbl_addr(tbl_addr),
  .tbl_size(tbl_size), .tbl_rdata(tbl_rdata), .mask_changed(mask_changed),
  .grant(grant), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/test_msix_vec_table.sv
`timescale 1ns/1ps
module test_msix_vec_table;
  localparam int NV = 8;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 0, cfg_write = 0;
  logic [3:0] cfg_addr = '0;
  logic [2:0] cfg_size = 3'd4;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic tbl_valid = 0, tbl_write = 0;
  logic [AW-1:0] tbl_addr = '0;
  logic [2:0] tbl_size = 3'd4;
  logic [31:0] tbl_wdata = '0, tbl_rdata;
  logic mask_changed;
  logic [NV-1:0] irq_req = '0;
  logic msg_valid, msg_ready = 0;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int n_chk = 0, n_fail = 0;
  logic [31:0] model [NV][4];

  always #5 clk = ~clk;

  msix_vec_table i_msix_vec_table (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [63:0] exp_addr(input int i);
    return {32'h0000_00F0 + 32'(i), 32'h1000_0000 + 32'(i * 16)};
  endfunction
  function automatic logic [31:0] exp_data(input int i);
    return 32'h00C0_0000 + 32'(i);
  endfunction
  function automatic logic [AW-1:0] ent_addr(input int v, input int f);
    return AW'(v * 16 + f * 4);
  endfunction

  task automatic cfg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); cfg_valid = 1; cfg_write = 0; cfg_addr = a; cfg_size = 3'd4;
    #1 d = cfg_rdata;
    @(negedge clk); cfg_valid = 0;
  endtask
  task automatic cfg_wr(input logic [3:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); cfg_valid = 1; cfg_write = 1; cfg_addr = a; cfg_size = s; cfg_wdata = d;
    @(negedge clk); cfg_valid = 0; cfg_write = 0;
  endtask
  task automatic tbl_rd(input logic [AW-1:0] a, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); tbl_valid = 1; tbl_write = 0; tbl_addr = a; tbl_size = s;
    #1 d = tbl_rdata;
    @(negedge clk); tbl_valid = 0;
  endtask
  task automatic tbl_wr(input logic [AW-1:0] a, input logic [2:0] s, input logic [31:0] d,
                        output logic mc);
    @(negedge clk); tbl_valid = 1; tbl_write = 1; tbl_addr = a; tbl_size = s; tbl_wdata = d;
    @(negedge clk); tbl_valid = 0; tbl_write = 0; mc = mask_changed;
  endtask
  task automatic pulse_irq(input logic [NV-1:0] v);
    @(negedge clk); irq_req = v;
    @(negedge clk); irq_req = '0;
  endtask
  task automatic wait_msg(input string req, input int vec);
    int k = 0;
    while (!msg_valid && k < 20) begin @(negedge clk); k++; end
    chk({req, " valid"}, 64'(msg_valid), 64'd1);
    chk({req, " addr"}, msg_addr, exp_addr(vec));
    chk({req, " data"}, 64'(msg_data), 64'(exp_data(vec)));
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic mc;
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset header
    cfg_rd(4'd0, d); chk("R1 header", 64'(d), 64'h0007_0011);
    // R3 locators
    cfg_rd(4'd4, d); chk("R3 table locator", 64'(d), 64'h0000_2002);
    cfg_rd(4'd8, d); chk("R3 pba locator", 64'(d), 64'h0000_3002);
    cfg_rd(4'd12, d); chk("R3 tail dword", 64'(d), 64'd0);
    // R5 reset entries
    for (int v = 0; v < NV; v++) begin
      tbl_rd(ent_addr(v, 3), 3'd4, d); chk("R5 reset mask", 64'(d), 64'd1);
      tbl_rd(ent_addr(v, 0), 3'd4, d); chk("R5 reset addr", 64'(d), 64'd0);
      for (int f = 0; f < 3; f++) model[v][f] = '0;
      model[v][3] = 32'd1;
    end

    // R2 header writes
    cfg_wr(4'd0, 3'd4, 32'hC000_0000); cfg_rd(4'd0, d);
    chk("R2 dword write ignored", 64'(d), 64'h0007_0011);
    cfg_wr(4'd2, 3'd1, 32'h0000_C0FF); cfg_rd(4'd0, d);
    chk("R2 byte write ignored", 64'(d), 64'h0007_0011);
    cfg_wr(4'd2, 3'd2, 32'h0000_FFFF); cfg_rd(4'd0, d);
    chk("R2 ctrl write", 64'(d), 64'hC007_0011);
    cfg_wr(4'd2, 3'd2, 32'h0000_0000); cfg_rd(4'd0, d);
    chk("R2 ctrl clear", 64'(d), 64'h0007_0011);

    // R4 / R8 random table traffic with shadow model
    for (int n = 0; n < 60; n++) begin
      int v, f;
      logic [31:0] w;
      logic expmc;
      v = int'($urandom_range(NV - 1));
      f = int'($urandom_range(3));
      w = $urandom;
      expmc = (f == 3) && (w[0] != model[v][3][0]);
      tbl_wr(ent_addr(v, f), 3'd4, w, mc);
      if (f == 3) begin
        chk("R8 mask_changed pulse", 64'(mc), 64'(expmc));
        model[v][3] = {31'd0, w[0]};
      end else model[v][f] = w;
    end
    @(negedge clk); chk("R8 pulse one cycle", 64'(mask_changed), 64'd0);
    for (int v = 0; v < NV; v++)
      for (int f = 0; f < 4; f++) begin
        tbl_rd(ent_addr(v, f), 3'd4, d);
        chk(f == 3 ? "R8 ctrl readback" : "R4 readback", 64'(d), 64'(model[v][f]));
      end

    // R6 bad size / alignment
    tbl_wr(ent_addr(1, 2) | AW'(1), 3'd4, 32'hDEAD_BEEF, mc);
    tbl_wr(ent_addr(1, 2), 3'd2, 32'hDEAD_BEEF, mc);
    tbl_rd(ent_addr(1, 2), 3'd4, d); chk("R6 bad write no effect", 64'(d), 64'(model[1][2]));
    tbl_rd(ent_addr(1, 2) | AW'(2), 3'd4, d); chk("R6 misaligned read", 64'(d), 64'd0);
    tbl_rd(ent_addr(1, 2), 3'd1, d); chk("R6 narrow read", 64'(d), 64'd0);
    // R7 index out of range
    tbl_wr(ent_addr(9, 0), 3'd4, 32'h5555_AAAA, mc);
    tbl_rd(ent_addr(1, 0), 3'd4, d); chk("R7 no alias write", 64'(d), 64'(model[1][0]));
    tbl_rd(ent_addr(9, 0), 3'd4, d); chk("R7 out of range read", 64'(d), 64'd0);

    // program entries for dispatch, all unmasked
    for (int v = 0; v < NV; v++) begin
      tbl_wr(ent_addr(v, 0), 3'd4, exp_addr(v)[31:0], mc);
      tbl_wr(ent_addr(v, 1), 3'd4, exp_addr(v)[63:32], mc);
      tbl_wr(ent_addr(v, 2), 3'd4, exp_data(v), mc);
      tbl_wr(ent_addr(v, 3), 3'd4, 32'd0, mc);
    end
    cfg_wr(4'd2, 3'd2, 32'h0000_8000);

    // R9 timing and content
    @(negedge clk); irq_req = NV'(1) << 5;
    @(negedge clk); irq_req = '0;
    chk("R9 not yet valid", 64'(msg_valid), 64'd0);
    @(negedge clk); chk("R9 valid after two edges", 64'(msg_valid), 64'd1);
    wait_msg("R9", 5);
    repeat (4) @(negedge clk); chk("R10 sent once", 64'(msg_valid), 64'd0);

    // R10 function mask holds pending
    cfg_wr(4'd2, 3'd2, 32'h0000_C000);
    pulse_irq(NV'(1) << 3);
    repeat (5) @(negedge clk); chk("R10 blocked by fn mask", 64'(msg_valid), 64'd0);
    cfg_wr(4'd2, 3'd2, 32'h0000_8000);
    wait_msg("R10 fn unmask", 3);
    repeat (4) @(negedge clk); chk("R10 no repeat", 64'(msg_valid), 64'd0);
    // R10 vector mask holds pending
    tbl_wr(ent_addr(6, 3), 3'd4, 32'd1, mc);
    pulse_irq(NV'(1) << 6);
    repeat (5) @(negedge clk); chk("R10 blocked by vec mask", 64'(msg_valid), 64'd0);
    tbl_wr(ent_addr(6, 3), 3'd4, 32'd0, mc);
    wait_msg("R10 vec unmask", 6);

    // R11 / R12 ordering and hold
    pulse_irq(8'b1001_0100);
    repeat (2) @(negedge clk);
    begin
      logic [63:0] a0;
      a0 = msg_addr;
      repeat (3) @(negedge clk);
      chk("R12 hold valid", 64'(msg_valid), 64'd1);
      chk("R12 hold addr", msg_addr, a0);
    end
    wait_msg("R11 first", 2);
    wait_msg("R11 second", 4);
    wait_msg("R11 third", 7);

    // random request bursts against lowest-first order
    for (int n = 0; n < 6; n++) begin
      logic [NV-1:0] r;
      r = NV'($urandom) | NV'(1);
      pulse_irq(r);
      for (int v = 0; v < NV; v++) if (r[v]) wait_msg("R11 random burst", v);
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule